// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block multiplies two 32-bit register operands and adds the product to, or subtracts it from, one of a bank of 48-bit accumulators. Either operand can be a full 32-bit longword or a 16-bit word taken from its upper or lower half and sign-extended. The full 64-bit product can be shifted one bit left or right before it is accumulated. The block flags a product that does not fit the accumulator's signed range. Each accumulator has its own sticky overflow flag, and one global sticky flag covers the whole bank. When saturation is enabled, an overflowing product sets the accumulator to a fixed limit. A set flag then freezes that accumulator until software clears the flags.

Operations come in on a valid/ready stream. `in_ready` is held high, so the block never applies back-pressure. Every cycle in which `in_valid` is high is one accepted operation. The result appears in the registers on the next rising edge. `acc_sel` picks the target accumulator. It also picks the one shown on `acc_rd`, which is a combinational read of the registered state. Only the signed-integer mode executes. The other mode codes are decoded and then dropped.

Top module: `sat_mac_unit`

## Requirements
- R1: In word mode (`long_op`=0), each operand uses bits 31:16 of its register when its half select (`x_hi`/`y_hi`) is 1, and bits 15:0 when it is 0. The chosen half is sign-extended to 32 bits.
- R2: In longword mode (`long_op`=1), both operands are the full 32-bit register values, read as signed.
- R3: When the product does not overflow, the selected accumulator becomes acc + P[47:0] (`subtract`=0) or acc − P[47:0] (`subtract`=1), modulo 2^48. P is the signed 64-bit product after the shift stage.
- R4: `shift_code` 2'b01 shifts the product left by one bit and inserts zero at bit 0. 2'b10 is an arithmetic right shift by one bit. 2'b00 and 2'b11 leave the product unshifted.
- R5: The unshifted product has overflowed when its bits 63:39 are neither all zeros nor all ones. An executed overflowing operation sets `acc_ovf[acc_sel]` and `ovf_v`.
- R6: With `sat_en`=1 and `subtract`=0, an overflowing product loads 48'hFFFF_8000_0000 into the accumulator if the product is negative, and 48'h0000_7FFF_FFFF if it is positive.
- R7: With `sat_en`=1 and `subtract`=1, the two limits swap. A negative product gives 48'h0000_7FFF_FFFF and a positive product gives 48'hFFFF_8000_0000.
- R8: When `sat_en`=1 and the selected accumulator's flag is set, an operation changes no accumulator and no flag.
- R9: When `sat_en`=0, an overflowing product is still accumulated as in R3 and still sets the flags. A set flag does not block later operations.
- R10: `mode` 2'b00 is signed integer. 2'b01 (signed fractional), 2'b10 (unsigned integer) and 2'b11 (unsigned fractional) are decoded but not executed: they leave the accumulators and flags unchanged.
- R11: The flags are cleared only by `clr_flags`. It clears every per-accumulator flag and `ovf_v` on the next edge. An operation accepted in the same cycle sees the flags already cleared, and its own overflow sets them again.
- R12: Synchronous reset zeroes every accumulator and flag. `in_ready` is always 1. A cycle with `in_valid`=0 changes no state. `acc_rd` shows the accumulator named by `acc_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_ready | output | 1 | Always 1; the block never stalls |
| op_x | input | 32 | First register operand |
| op_y | input | 32 | Second register operand |
| long_op | input | 1 | 1 = longword operands, 0 = word operands |
| x_hi | input | 1 | Word mode: take upper half of op_x |
| y_hi | input | 1 | Word mode: take upper half of op_y |
| shift_code | input | 2 | 00/11 none, 01 left, 10 right |
| subtract | input | 1 | 0 = accumulate, 1 = subtract from accumulator |
| mode | input | 2 | Operating mode; only 00 executes |
| sat_en | input | 1 | Saturation and overflow freeze enable |
| acc_sel | input | 2 | Target and readback accumulator |
| clr_flags | input | 1 | Clear all sticky overflow flags |
| acc_rd | output | 48 | Value of the accumulator picked by acc_sel |
| acc_ovf | output | 4 | Sticky overflow flag per accumulator |
| ovf_v | output | 1 | Global sticky overflow flag |

## Verification
The bench drives products at exactly +2^39 and −2^39. A design that tested the wrong bit span, or checked only the sign bit, would misflag one of the two. It saturates in both add and subtract directions with both product signs, so a design with the limit polarity unswapped, or keyed on the result sign, would load the wrong constant. It then sends small operations to a frozen accumulator, with saturation on and with it off: a design that ignored the freeze, or applied it without saturation, changes the accumulator or leaves it stuck. It also drives a clear in the same cycle as a new overflow, and sends the three non-executing modes with valid high, which a design that executed them would accumulate.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_NONE2 = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    MODE_SINT  = 2'b00,
    MODE_SFRAC = 2'b01,
    MODE_UINT  = 2'b10,
    MODE_UFRAC = 2'b11
  } mode_e;

  // Positive limit: largest signed value of a register-width word,
  // zero-extended to the accumulator width.
  function automatic logic [63:0] sat_pos_lim(input int data_w);
    logic [63:0] v;
    v = 64'd0;
    for (int i = 0; i < data_w - 1; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Negative limit: smallest signed register-width value, sign-extended.
  function automatic logic [63:0] sat_neg_lim(input int data_w);
    logic [63:0] v;
    v = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < data_w - 1; i++) v[i] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] reg_val,
  input  logic              long_op,
  input  logic              take_hi,
  output logic [DATA_W-1:0] operand
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] half;

  always_comb begin
    half = take_hi ? reg_val[DATA_W-1:HALF_W] : reg_val[HALF_W-1:0];
    if (long_op) operand = reg_val;
    else         operand = {{(DATA_W-HALF_W){half[HALF_W-1]}}, half};
  end

  AST_WORD_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    !long_op |-> (operand[DATA_W-1:HALF_W] == {HALF_W{operand[HALF_W-1]}})); // R1

endmodule

// File: rtl/mac_product.sv
module mac_product
  import sat_mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int OVF_LSB = 39
) (
  input  logic [DATA_W-1:0] opx,
  input  logic [DATA_W-1:0] opy,
  input  logic [1:0]        shift_code,
  input  logic              frac_mode,
  output logic              prod_neg,
  output logic              prod_ovf,
  output logic [ACC_W-1:0]  prod_acc
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int HI_W   = PROD_W - OVF_LSB;

  logic signed [PROD_W-1:0] xe, ye, prod;
  logic [HI_W-1:0]          hi_bits;
  shift_e                   sh;

  always_comb begin
    xe      = $signed({{(PROD_W-DATA_W){opx[DATA_W-1]}}, opx});
    ye      = $signed({{(PROD_W-DATA_W){opy[DATA_W-1]}}, opy});
    prod    = xe * ye;
    hi_bits = prod[PROD_W-1:OVF_LSB];
    // Overflow: top bits not a pure sign extension.
    prod_ovf = (|hi_bits) && !(&hi_bits);
    prod_neg = prod[PROD_W-1];
    sh = frac_mode ? SH_NONE : shift_e'(shift_code);
    // A right shift's fill lands in bit PROD_W-1, above the accumulator,
    // so only bits ACC_W:1 of the product reach the result.
    case (sh)
      SH_LEFT:  prod_acc = {prod[ACC_W-2:0], 1'b0};
      SH_RIGHT: prod_acc = prod[ACC_W:1];
      default:  prod_acc = prod[ACC_W-1:0];
    endcase
  end

endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int NACC  = 4,
  parameter int ACC_W = 48,
  localparam int SEL_W = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_idx,
  input  logic [ACC_W-1:0]           wr_data,
  input  logic                       set_ovf,
  input  logic                       clr_flags,
  output logic [NACC-1:0][ACC_W-1:0] acc_all,
  output logic [NACC-1:0]            flags,
  output logic                       ovf_v
);

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic hit;
    assign hit = (wr_idx == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_all[g] <= '0;
        flags[g]   <= 1'b0;
      end else begin
        if (wr_en && hit) acc_all[g] <= wr_data;
        if (set_ovf && hit) flags[g] <= 1'b1;
        else if (clr_flags) flags[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_v <= 1'b0;
    else if (set_ovf) ovf_v <= 1'b1;
    else if (clr_flags) ovf_v <= 1'b0;
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_flags |=> ((flags & $past(flags)) == $past(flags))); // R11

  AST_V_COVERS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (|flags) |-> ovf_v); // R5

endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int NACC    = 4,
  parameter int DATA_W  = 32,
  parameter int ACC_W   = 48,
  parameter int OVF_LSB = 39,
  localparam int SEL_W  = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_x,
  input  logic [DATA_W-1:0] op_y,
  input  logic              long_op,
  input  logic              x_hi,
  input  logic              y_hi,
  input  logic [1:0]        shift_code,
  input  logic              subtract,
  input  logic [1:0]        mode,
  input  logic              sat_en,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic              clr_flags,
  output logic [ACC_W-1:0]  acc_rd,
  output logic [NACC-1:0]   acc_ovf,
  output logic              ovf_v
);
  localparam logic [63:0] POS_W = sat_pos_lim(DATA_W);
  localparam logic [63:0] NEG_W = sat_neg_lim(DATA_W);
  localparam logic [ACC_W-1:0] SAT_POS = POS_W[ACC_W-1:0];
  localparam logic [ACC_W-1:0] SAT_NEG = NEG_W[ACC_W-1:0];

  logic [DATA_W-1:0]          opx, opy;
  logic                       prod_neg, prod_ovf;
  logic [ACC_W-1:0]           prod_acc;
  logic [NACC-1:0][ACC_W-1:0] acc_all;
  logic [ACC_W-1:0]           cur_acc, next_acc;
  logic                       sel_flag, exec, sint;

  assign in_ready = 1'b1;

  mac_operand_sel #(.DATA_W(DATA_W)) u_sel_x (
    .clk(clk), .rst(rst), .reg_val(op_x), .long_op(long_op),
    .take_hi(x_hi), .operand(opx));

  mac_operand_sel #(.DATA_W(DATA_W)) u_sel_y (
    .clk(clk), .rst(rst), .reg_val(op_y), .long_op(long_op),
    .take_hi(y_hi), .operand(opy));

  mac_product #(.DATA_W(DATA_W), .ACC_W(ACC_W), .OVF_LSB(OVF_LSB)) u_prod (
    .opx(opx), .opy(opy), .shift_code(shift_code), .frac_mode(mode[0]),
    .prod_neg(prod_neg), .prod_ovf(prod_ovf), .prod_acc(prod_acc));

  always_comb begin
    sint     = (mode_e'(mode) == MODE_SINT);
    cur_acc  = acc_all[acc_sel];
    // Flag as seen after a same-cycle clear.
    sel_flag = acc_ovf[acc_sel] && !clr_flags;
    exec     = in_valid && in_ready && sint && !(sat_en && sel_flag);
    if (sat_en && prod_ovf)
      next_acc = (prod_neg ^ subtract) ? SAT_NEG : SAT_POS;
    else if (subtract)
      next_acc = cur_acc - prod_acc;
    else
      next_acc = cur_acc + prod_acc;
  end

  mac_acc_bank #(.NACC(NACC), .ACC_W(ACC_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(exec), .wr_idx(acc_sel), .wr_data(next_acc),
    .set_ovf(exec && prod_ovf), .clr_flags(clr_flags),
    .acc_all(acc_all), .flags(acc_ovf), .ovf_v(ovf_v));

  assign acc_rd = acc_all[acc_sel];

  AST_FROZEN_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && !clr_flags && acc_ovf[acc_sel])
      |=> (acc_all == $past(acc_all)) && (acc_ovf == $past(acc_ovf))
          && (ovf_v == $past(ovf_v))); // R8

  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'b00) && sat_en && prod_ovf
       && !(acc_ovf[acc_sel] && !clr_flags))
      |=> (acc_all[$past(acc_sel)] == SAT_POS)
          || (acc_all[$past(acc_sel)] == SAT_NEG)); // R6

  AST_MODE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode != 2'b00) && !clr_flags)
      |=> (acc_all == $past(acc_all)) && (acc_ovf == $past(acc_ovf))); // R10

endmodule

// File: tb/sat_mac_unit_test.sv
module sat_mac_unit_test;

  typedef struct packed {
    logic        vld;
    logic [31:0] x;
    logic [31:0] y;
    logic        lng;
    logic        xh;
    logic        yh;
    logic [1:0]  sh;
    logic        sub;
    logic [1:0]  md;
    logic        sat;
    logic [1:0]  sel;
    logic        clr;
  } vec_t;

  localparam int NV = 19;
  // vld x y lng xh yh sh sub md sat sel clr
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 32'h0000_FFFE, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0}, // R1 low halves
    '{1'b1, 32'h7FFF_1234, 32'h8000_5678, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 2'b00, 1'b0, 2'd0, 1'b0}, // R1 high halves, MSAC
    '{1'b1, 32'h0001_0000, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'd1, 1'b0}, // R2 longword
    '{1'b1, 32'h0000_0003, 32'h0000_0005, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 2'b00, 1'b0, 2'd1, 1'b0}, // R4 left
    '{1'b1, 32'hFFFF_FFF9, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 2'b00, 1'b0, 2'd1, 1'b0}, // R4 right
    '{1'b1, 32'h0000_0009, 32'h0000_0002, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 2'b00, 1'b0, 2'd1, 1'b0}, // R3 MSAC, code 11
    '{1'b1, 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b01, 1'b0, 2'd1, 1'b0}, // R10 mode 01
    '{1'b1, 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b10, 1'b0, 2'd1, 1'b0}, // R10 mode 10
    '{1'b0, 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'd1, 1'b0}, // R12 idle
    '{1'b1, 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'd2, 1'b0}, // R6 pos clamp
    '{1'b1, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'd2, 1'b0}, // R8 frozen
    '{1'b1, 32'h8000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 2'd3, 1'b0}, // R7 neg product
    '{1'b1, 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 2'b00, 1'b1, 2'd3, 1'b1}, // R11 clear + R7
    '{1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'd2, 1'b0}, // R6 neg clamp
    '{1'b1, 32'h4000_0001, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0}, // R9 wrap
    '{1'b1, 32'h0000_0002, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0}, // R9 not frozen
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 2'd0, 1'b1}, // R11 clear only
    '{1'b1, 32'hFF80_0000, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'd0, 1'b0}, // R5 -2^39 fits
    '{1'b1, 32'h0080_0000, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'd1, 1'b0}  // R5 +2^39 over
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:     return "R1";
      2:        return "R2";
      3, 4:     return "R4";
      5:        return "R3";
      6, 7:     return "R10";
      8:        return "R12";
      9, 13:    return "R6";
      10:       return "R8";
      11:       return "R7";
      12, 16:   return "R11";
      14, 15:   return "R9";
      default:  return "R5";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_x = '0, op_y = '0;
  logic        long_op = 1'b0, x_hi = 1'b0, y_hi = 1'b0;
  logic [1:0]  shift_code = '0;
  logic        subtract = 1'b0;
  logic [1:0]  mode = '0;
  logic        sat_en = 1'b0;
  logic [1:0]  acc_sel = '0;
  logic        clr_flags = 1'b0;
  logic [47:0] acc_rd;
  logic [3:0]  acc_ovf;
  logic        ovf_v;

  int n_chk = 0;
  int n_bad = 0;

  logic [47:0] m_acc [4];
  logic [3:0]  m_flag;
  logic        m_v;

  always #5 clk = ~clk;

  sat_mac_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_x(op_x), .op_y(op_y), .long_op(long_op), .x_hi(x_hi), .y_hi(y_hi),
    .shift_code(shift_code), .subtract(subtract), .mode(mode),
    .sat_en(sat_en), .acc_sel(acc_sel), .clr_flags(clr_flags),
    .acc_rd(acc_rd), .acc_ovf(acc_ovf), .ovf_v(ovf_v));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] pick(input logic [31:0] r, input logic lng, input logic hi);
    if (lng) return r;
    return hi ? {{16{r[31]}}, r[31:16]} : {{16{r[15]}}, r[15:0]};
  endfunction

  // Reference model written from the requirements.
  task automatic model(input vec_t v);
    logic signed [63:0] p, sp;
    logic [24:0] hb;
    logic ovf;
    logic [31:0] a, b;
    if (v.clr) begin m_flag = '0; m_v = 1'b0; end
    if (!v.vld || v.md != 2'b00) return;
    if (v.sat && m_flag[v.sel]) return;
    a = pick(v.x, v.lng, v.xh);
    b = pick(v.y, v.lng, v.yh);
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    hb = p[63:39];
    ovf = (hb != '0) && (hb != '1);
    case (v.sh)
      2'b01:   sp = p <<< 1;
      2'b10:   sp = (ovf || p == 0) ? {1'b0, p[63:1]} : (p >>> 1);
      default: sp = p;
    endcase
    if (ovf) begin m_flag[v.sel] = 1'b1; m_v = 1'b1; end
    if (ovf && v.sat)
      m_acc[v.sel] = (p[63] ^ v.sub) ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
    else if (v.sub)
      m_acc[v.sel] = m_acc[v.sel] - sp[47:0];
    else
      m_acc[v.sel] = m_acc[v.sel] + sp[47:0];
  endtask

  task automatic drive(input vec_t v);
    in_valid = v.vld; op_x = v.x; op_y = v.y; long_op = v.lng;
    x_hi = v.xh; y_hi = v.yh; shift_code = v.sh; subtract = v.sub;
    mode = v.md; sat_en = v.sat; acc_sel = v.sel; clr_flags = v.clr;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_flag = '0; m_v = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; clr_flags = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic reset_checks();
    for (int i = 0; i < 4; i++) begin
      acc_sel = 2'(i);
      #1;
      check("R12 reset acc", {16'd0, acc_rd}, 64'd0);
    end
    check("R12 reset flags", {59'd0, acc_ovf, ovf_v}, 64'd0);
    check("R12 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t d;
    do_reset();
    @(negedge clk);
    reset_checks();

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      model(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0; clr_flags = 1'b0;
      check({vec_tag(i), " acc"}, {16'd0, acc_rd}, {16'd0, m_acc[VECS[i].sel]});
      check({vec_tag(i), " flags"}, {59'd0, acc_ovf, ovf_v}, {59'd0, m_flag, m_v});
    end

    // Directed: literal clamp values after a fresh reset.
    do_reset();
    d = '{1'b1, 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 2'd2, 1'b0};
    drive(d);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 literal pos", {16'd0, acc_rd}, 64'h0000_0000_7FFF_FFFF);
    check("R5 flag set", {59'd0, acc_ovf, ovf_v}, {59'd0, 4'b0100, 1'b1});
    d.sub = 1'b1; d.sel = 2'd3;
    drive(d);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 literal", {16'd0, acc_rd}, 64'h0000_FFFF_8000_0000);

    // Directed: mode 11 with valid does nothing.
    d = '{1'b1, 32'h0000_0010, 32'h0000_0010, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'b11, 1'b0, 2'd0, 1'b0};
    drive(d);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 mode 11", {16'd0, acc_rd}, 64'd0);

    // Directed: mid-run reset clears everything.
    do_reset();
    @(negedge clk);
    reset_checks();

    finish_run();
  end

endmodule